// File: doc/BRIEF.md
# Boot Block Swap Address Decoder

This decoder sits on the processor memory path and classifies each memory cycle near the top of the 32-bit address space. Cycles in the upper 128 KB go to the firmware flash or, when the boot destination select is cleared, to PCI. Cycles in a small timer register window go to the timer target. Every other cycle reports that no target claimed it. The result and the address to present downstream appear one clock after the cycle strobe.

Safe boot code updates rely on a swap mode. With swap on, address bit 16 of every cycle decoded to flash is inverted. The top 64 KB block and the block directly below it then trade places, so firmware can rewrite the boot block while a verified copy is still being fetched. The swap bit and its lock-down bit are kept in the RTC power well. Only the RTC-well reset clears them, and a platform reset leaves them untouched. Once the lock bit is set, the swap setting is frozen until the next RTC-well reset.

Top module: `bootswap_decoder`

## Requirements
- R1: While the platform reset is asserted, and right after it, out_valid is 0, out_tgt is 0 (no target) and timer_hit is 0.
- R2: A cycle presented with cyc_valid=1 at one rising edge produces out_valid=1 with its decode after that edge. When cyc_valid was 0, out_valid is 0 after the edge.
- R3: An address in FFFE_0000h–FFFF_FFFFh, with boot destination 1, firmware enable 1 and swap 0, gives out_tgt=1 (flash) and out_addr equal to the input address.
- R4: With swap 1, a flash cycle has out_addr equal to the input with bit 16 inverted, so FFFF_xxxxh maps to FFFE_xxxxh and FFFE_xxxxh maps to FFFF_xxxxh.
- R5: For every cycle whose out_tgt is not flash, out_addr equals the input address, whatever the swap bit is.
- R6: With boot destination 0, any address in FFFE_0000h–FFFF_FFFFh gives out_tgt=2 (PCI), whatever the firmware enable and swap bits are.
- R7: With boot destination 1 and firmware enable 0, the top 128 KB gives out_tgt=0.
- R8: An address FED0_X000h–FED0_X3FFh, where X equals the 2-bit timer select, gives out_tgt=3 and timer_hit=1. Offsets X400h–XFFFh, and windows with any other X, do not hit.
- R9: Any address outside the flash range and the selected timer window gives out_tgt=0 and timer_hit=0.
- R10: Register writes take effect from the cycle after cfg_we. Register 0 (cfg_addr=0) holds swap in bit 0 and lock in bit 1. Register 1 holds firmware enable in bit 0, boot destination in bit 1 and the timer select in bits 3:2.
- R11: While lock is 1, writes to register 0 are ignored, so neither the swap bit nor the lock bit changes.
- R12: The RTC-well reset clears swap and lock. The platform reset leaves them unchanged and returns register 1 to firmware enable 1, boot destination 1 and timer select 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rtc_rst_n | input | 1 | RTC-well reset, active low, asynchronous |
| plat_rst_n | input | 1 | Platform reset, active low, asynchronous |
| cfg_we | input | 1 | Control register write strobe |
| cfg_addr | input | 1 | Control register select (0: swap/lock, 1: decode control) |
| cfg_wdata | input | 4 | Control register write data |
| cyc_valid | input | 1 | Memory cycle strobe |
| cyc_addr | input | 32 | Memory cycle address |
| out_valid | output | 1 | Decode result valid |
| out_tgt | output | 2 | Target: 0 none, 1 flash, 2 PCI, 3 timer |
| out_addr | output | 32 | Address to present to the target |
| timer_hit | output | 1 | Cycle hit the selected timer window |

## Verification
Random addresses are drawn from four pools: the top 128 KB, the four timer windows at every offset, the page just past each window, and the full 32-bit space. Register 1 is rewritten at random between cycles. Together these separate flash from PCI from no-target routing, and they catch a window decoded for the wrong select value or with too wide a span. Directed cases walk the swap-based update sequence across both top blocks and then attempt to change a locked swap bit. They then apply each reset on its own, which shows which bits live in the RTC well and which are restored by the platform reset. Timer accesses made with swap on show that the inversion stays confined to flash cycles.

// File: rtl/bsd_pkg.sv
package bsd_pkg;
   typedef enum logic [1:0] {
      TGT_NONE  = 2'd0,
      TGT_FLASH = 2'd1,
      TGT_PCI   = 2'd2,
      TGT_TIMER = 2'd3
   } tgt_e;
endpackage

// File: rtl/bsd_ctrl_regs.sv
module bsd_ctrl_regs #(
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rtc_rst_n,
   input  logic             plat_rst_n,
   input  logic             cfg_we,
   input  logic             cfg_addr,
   input  logic [SEL_W+1:0] cfg_wdata,
   output logic             swap_o,
   output logic             lock_o,
   output logic             fw_en_o,
   output logic             boot_dest_o,
   output logic [SEL_W-1:0] timer_sel_o
);
   localparam logic WELL_REG = 1'b0;
   localparam logic PLAT_REG = 1'b1;

   if (SEL_W < 1) begin : g_bad_sel
      $error("bsd_ctrl_regs: SEL_W must be at least 1");
   end

   logic well_wr, plat_wr;
   assign well_wr = cfg_we && (cfg_addr == WELL_REG) && !lock_o;
   assign plat_wr = cfg_we && (cfg_addr == PLAT_REG);

   // RTC-well bits: only the RTC-well reset clears them
   always_ff @(posedge clk or negedge rtc_rst_n) begin
      if (!rtc_rst_n) begin
         swap_o <= 1'b0;
         lock_o <= 1'b0;
      end else if (well_wr) begin
         swap_o <= cfg_wdata[0];
         lock_o <= cfg_wdata[1];
      end
   end

   // Platform-domain decode controls
   always_ff @(posedge clk or negedge plat_rst_n) begin
      if (!plat_rst_n) begin
         fw_en_o     <= 1'b1;
         boot_dest_o <= 1'b1;
         timer_sel_o <= '0;
      end else if (plat_wr) begin
         fw_en_o     <= cfg_wdata[0];
         boot_dest_o <= cfg_wdata[1];
         timer_sel_o <= cfg_wdata[SEL_W+1:2];
      end
   end

   // R11: lock stays set until the RTC-well reset
   a_r11_lock_sticky : assert property (@(posedge clk) disable iff (!rtc_rst_n)
      lock_o |=> lock_o);
   // R11: swap cannot move once locked
   a_r11_swap_frozen : assert property (@(posedge clk) disable iff (!rtc_rst_n)
      lock_o |=> $stable(swap_o));
   // R10: a register 1 write is visible on the next cycle
   a_r10_plat_write : assert property (@(posedge clk) disable iff (!plat_rst_n)
      (cfg_we && cfg_addr) |=> (boot_dest_o == $past(cfg_wdata[1])));
endmodule

// File: rtl/bsd_range_decode.sv
module bsd_range_decode
   import bsd_pkg::*;
#(
   parameter int          ADDR_W            = 32,
   parameter int          BLOCK_BITS        = 16,
   parameter logic [31:0] TIMER_BASE        = 32'hFED0_0000,
   parameter int          TIMER_STRIDE_BITS = 12,
   parameter int          TIMER_WIN_BITS    = 10,
   parameter int          SEL_W             = 2
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              swap_i,
   input  logic              fw_en_i,
   input  logic              boot_dest_i,
   input  logic [SEL_W-1:0]  timer_sel_i,
   output tgt_e              tgt_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              timer_hit_o
);
   localparam int HI_W    = ADDR_W - TIMER_STRIDE_BITS;
   localparam int GAP_W   = TIMER_STRIDE_BITS - TIMER_WIN_BITS;
   localparam int FW_LSB  = BLOCK_BITS + 1;
   localparam logic [HI_W-1:0]   TIMER_HI  = TIMER_BASE[ADDR_W-1:TIMER_STRIDE_BITS];
   localparam logic [ADDR_W-1:0] SWAP_MASK = {{(ADDR_W-1){1'b0}}, 1'b1} << BLOCK_BITS;

   if (ADDR_W != 32) begin : g_bad_aw
      $error("bsd_range_decode: only a 32-bit address space is supported");
   end
   if (FW_LSB >= ADDR_W) begin : g_bad_blk
      $error("bsd_range_decode: BLOCK_BITS too large");
   end
   if (TIMER_WIN_BITS >= TIMER_STRIDE_BITS) begin : g_bad_win
      $error("bsd_range_decode: timer window must be smaller than its stride");
   end
   if ((TIMER_BASE[TIMER_STRIDE_BITS+SEL_W-1:0]) != '0) begin : g_bad_base
      $error("bsd_range_decode: timer base must be aligned to all select values");
   end

   logic              in_fw, in_timer;
   logic [HI_W-1:0]   win_tag;

   assign in_fw   = &addr_i[ADDR_W-1:FW_LSB];
   assign win_tag = TIMER_HI + HI_W'(timer_sel_i);
   assign in_timer = (addr_i[ADDR_W-1:TIMER_STRIDE_BITS] == win_tag) &&
                     (addr_i[TIMER_STRIDE_BITS-1:TIMER_WIN_BITS] == GAP_W'(0));

   always_comb begin
      tgt_o       = TGT_NONE;
      addr_o      = addr_i;
      timer_hit_o = 1'b0;
      if (in_fw) begin
         if (!boot_dest_i) begin
            tgt_o = TGT_PCI;
         end else if (fw_en_i) begin
            tgt_o  = TGT_FLASH;
            addr_o = swap_i ? (addr_i ^ SWAP_MASK) : addr_i;
         end
      end else if (in_timer) begin
         tgt_o       = TGT_TIMER;
         timer_hit_o = 1'b1;
      end
   end
endmodule

// File: rtl/bootswap_decoder.sv
module bootswap_decoder
   import bsd_pkg::*;
#(
   parameter int          ADDR_W            = 32,
   parameter int          BLOCK_BITS        = 16,
   parameter logic [31:0] TIMER_BASE        = 32'hFED0_0000,
   parameter int          TIMER_STRIDE_BITS = 12,
   parameter int          TIMER_WIN_BITS    = 10,
   parameter int          TIMER_SEL_W       = 2
) (
   input  logic                   clk,
   input  logic                   rtc_rst_n,
   input  logic                   plat_rst_n,
   input  logic                   cfg_we,
   input  logic                   cfg_addr,
   input  logic [TIMER_SEL_W+1:0] cfg_wdata,
   input  logic                   cyc_valid,
   input  logic [ADDR_W-1:0]      cyc_addr,
   output logic                   out_valid,
   output logic [1:0]             out_tgt,
   output logic [ADDR_W-1:0]      out_addr,
   output logic                   timer_hit
);
   logic                   swap, lock, fw_en, boot_dest;
   logic [TIMER_SEL_W-1:0] timer_sel;
   tgt_e                   dec_tgt;
   logic [ADDR_W-1:0]      dec_addr;
   logic                   dec_hit;

   bsd_ctrl_regs #(.SEL_W(TIMER_SEL_W)) u_regs (
      .clk(clk), .rtc_rst_n(rtc_rst_n), .plat_rst_n(plat_rst_n),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .swap_o(swap), .lock_o(lock), .fw_en_o(fw_en),
      .boot_dest_o(boot_dest), .timer_sel_o(timer_sel)
   );

   bsd_range_decode #(
      .ADDR_W(ADDR_W), .BLOCK_BITS(BLOCK_BITS), .TIMER_BASE(TIMER_BASE),
      .TIMER_STRIDE_BITS(TIMER_STRIDE_BITS), .TIMER_WIN_BITS(TIMER_WIN_BITS),
      .SEL_W(TIMER_SEL_W)
   ) u_dec (
      .addr_i(cyc_addr), .swap_i(swap), .fw_en_i(fw_en),
      .boot_dest_i(boot_dest), .timer_sel_i(timer_sel),
      .tgt_o(dec_tgt), .addr_o(dec_addr), .timer_hit_o(dec_hit)
   );

   always_ff @(posedge clk or negedge plat_rst_n) begin
      if (!plat_rst_n) begin
         out_valid <= 1'b0;
         out_tgt   <= TGT_NONE;
         out_addr  <= '0;
         timer_hit <= 1'b0;
      end else begin
         out_valid <= cyc_valid;
         out_tgt   <= cyc_valid ? dec_tgt : TGT_NONE;
         out_addr  <= cyc_valid ? dec_addr : '0;
         timer_hit <= cyc_valid && dec_hit;
      end
   end

   // R2: one-cycle decode latency
   a_r2_valid_follows : assert property (@(posedge clk) disable iff (!plat_rst_n)
      cyc_valid |=> out_valid);
   a_r2_idle_follows : assert property (@(posedge clk) disable iff (!plat_rst_n)
      !cyc_valid |=> !out_valid);
   // R5: non-flash cycles keep their address
   a_r5_nonflash_kept : assert property (@(posedge clk) disable iff (!plat_rst_n)
      (out_valid && out_tgt != TGT_FLASH) |-> (out_addr == $past(cyc_addr)));
   // R4: flash cycles carry bit 16 flipped exactly when swap was on
   a_r4_flash_bit : assert property (@(posedge clk) disable iff (!plat_rst_n || !rtc_rst_n)
      (out_valid && out_tgt == TGT_FLASH) |->
      (out_addr[BLOCK_BITS] == ($past(cyc_addr[BLOCK_BITS]) ^ $past(swap))));
   // R8: timer flag only with a valid timer target
   a_r8_hit_target : assert property (@(posedge clk) disable iff (!plat_rst_n)
      timer_hit |-> (out_valid && out_tgt == TGT_TIMER));
endmodule

// File: tb/bootswap_decoder_tb_top.sv
module bootswap_decoder_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rtc_rst_n = 1'b0, plat_rst_n = 1'b0;
   logic        cfg_we = 1'b0, cfg_addr = 1'b0;
   logic [3:0]  cfg_wdata = '0;
   logic        cyc_valid = 1'b0;
   logic [31:0] cyc_addr = '0;
   logic        out_valid, timer_hit;
   logic [1:0]  out_tgt;
   logic [31:0] out_addr;

   int n_tests = 0, n_fail = 0;
   logic m_swap = 0, m_lock = 0, m_fw = 1, m_bd = 1;
   logic [1:0] m_sel = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bootswap_decoder dut_i (
      .clk(clk), .rtc_rst_n(rtc_rst_n), .plat_rst_n(plat_rst_n),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .cyc_valid(cyc_valid), .cyc_addr(cyc_addr),
      .out_valid(out_valid), .out_tgt(out_tgt), .out_addr(out_addr),
      .timer_hit(timer_hit)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [1:0] exp_tgt(input logic [31:0] a);
      if (&a[31:17]) return !m_bd ? 2'd2 : (m_fw ? 2'd1 : 2'd0);
      if (a[31:12] == (20'hFED00 + {18'd0, m_sel}) && a[11:10] == 2'b00) return 2'd3;
      return 2'd0;
   endfunction

   function automatic logic [31:0] exp_addr(input logic [31:0] a);
      if (exp_tgt(a) == 2'd1 && m_swap) return a ^ 32'h0001_0000;
      return a;
   endfunction

   function automatic string req_of(input logic [31:0] a);
      case (exp_tgt(a))
         2'd1: return m_swap ? "R4" : "R3";
         2'd2: return "R6";
         2'd3: return "R8";
         default: return (&a[31:17]) ? "R7" : "R9";
      endcase
   endfunction

   task automatic access(input logic [31:0] a);
      logic [1:0] et;
      et = exp_tgt(a);
      @(negedge clk);
      cyc_valid = 1'b1; cyc_addr = a;
      @(negedge clk);
      cyc_valid = 1'b0;
      chk({req_of(a), " tgt"}, {30'd0, out_tgt}, {30'd0, et});
      chk(et == 2'd1 ? {req_of(a), " addr"} : "R5 addr", out_addr, exp_addr(a));
      chk({req_of(a), " hit/valid"}, {30'd0, timer_hit, out_valid}, {30'd0, et == 2'd3, 1'b1});
   endtask

   task automatic wr(input logic a, input logic [3:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      if (a) begin
         m_fw = d[0]; m_bd = d[1]; m_sel = d[3:2];
      end else if (!m_lock) begin
         m_swap = d[0]; m_lock = d[1];
      end
   endtask

   task automatic plat_reset();
      @(negedge clk);
      plat_rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk("R1 in reset", {29'd0, out_valid, out_tgt}, 32'd0);
      plat_rst_n = 1'b1;
      m_fw = 1; m_bd = 1; m_sel = 0;
   endtask

   task automatic rtc_reset();
      @(negedge clk);
      rtc_rst_n = 1'b0; plat_rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rtc_rst_n = 1'b1; plat_rst_n = 1'b1;
      m_swap = 0; m_lock = 0; m_fw = 1; m_bd = 1; m_sel = 0;
   endtask

   function automatic logic [31:0] rand_addr();
      logic [1:0] k;
      logic [1:0] x;
      k = 2'($urandom % 4);
      x = 2'($urandom % 4);
      case (k)
         2'd0: return {15'h7FFF, 17'($urandom)};
         2'd1: return {20'hFED00 + {18'd0, x}, 2'b00, 10'($urandom)};
         2'd2: return {20'hFED00 + {18'd0, x}, 12'($urandom)};
         default: return $urandom;
      endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk("R1 reset outputs", {29'd0, out_valid, out_tgt}, 32'd0);
      chk("R1 reset hit", {31'd0, timer_hit}, 32'd0);
      rtc_rst_n = 1'b1; plat_rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release", {29'd0, out_valid, out_tgt}, 32'd0);

      // R12 defaults: flash target, unswapped
      access(32'hFFFF_0000);
      // R2: idle cycle after a decode
      @(negedge clk);
      chk("R2 idle valid", {31'd0, out_valid}, 32'd0);

      // random phase
      for (int i = 0; i < 400; i++) begin
         if (i % 8 == 0) wr(1'b1, 4'($urandom));
         if (i % 16 == 4) wr(1'b0, {2'b00, 1'b0, 1'($urandom)});
         access(rand_addr());
      end

      // update sequence
      wr(1'b1, 4'b0111);                 // R10: fw on, flash dest, sel 1
      wr(1'b0, 4'b0001);                 // swap on
      access(32'hFFFF_1234);             // R4 -> FFFE_1234
      chk("R4 top->below", out_addr, 32'hFFFE_1234);
      access(32'hFFFE_ABCD);
      chk("R4 below->top", out_addr, 32'hFFFF_ABCD);
      access(32'hFED0_1010);             // R5/R8 timer unaffected by swap
      access(32'hFED0_13FF);             // R8 upper edge
      access(32'hFED0_1400);             // R8 past window
      access(32'hFED0_0000);             // R8 other select
      access(32'h0001_0000);             // R5/R9 bit 16 set, no target
      chk("R5 low addr kept", out_addr, 32'h0001_0000);
      wr(1'b1, 4'b0100);                 // R6 dest PCI, fw off
      access(32'hFFFF_8000);
      wr(1'b1, 4'b0110);                 // R7 fw off, flash dest
      access(32'hFFFE_0000);
      wr(1'b1, 4'b0011);
      plat_reset();                      // R12 swap survives
      access(32'hFFFF_0004);
      chk("R12 swap kept", out_addr, 32'hFFFE_0004);
      wr(1'b0, 4'b0000);                 // clear swap
      access(32'hFFFF_0004);
      wr(1'b0, 4'b0010);                 // lock
      wr(1'b0, 4'b0001);                 // R11 ignored
      access(32'hFFFF_0008);
      chk("R11 swap held", out_addr, 32'hFFFF_0008);
      wr(1'b0, 4'b0000);                 // R11 unlock attempt ignored
      wr(1'b0, 4'b0001);
      access(32'hFFFF_000C);
      plat_reset();                      // R12 lock survives
      wr(1'b0, 4'b0001);
      access(32'hFFFF_0010);
      chk("R12 lock kept", out_addr, 32'hFFFF_0010);
      rtc_reset();                       // R12 clears lock
      wr(1'b0, 4'b0001);
      access(32'hFFFF_0014);
      chk("R12 lock cleared", out_addr, 32'hFFFE_0014);
      rtc_reset();
      access(32'hFFFE_0018);
      chk("R12 swap cleared", out_addr, 32'hFFFE_0018);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule